// File: doc/BRIEF.md
# Match-Compare Timer Bank

This block holds a bank of independent up-counters behind a simple word-addressed register port. Each counter has a small set of match comparators. When the running count equals a match value, that comparator raises a sticky status bit. Each counter drives one interrupt line. That line is high whenever any of its status bits is set and that bit's interrupt enable is also set.

Each counter runs in one of two reload modes. In free-running mode it counts through the full 32-bit range and wraps. In periodic mode it returns to zero on the cycle after it hits match comparator 0, so a match value of N-1 gives a period of N cycles. Software starts and stops the counters through one run register that has a bit per counter. Stopping one counter leaves the others running. Status bits are cleared by writing ones to the status register.

Top module: `mct_bank`

## Requirements
- R1: After reset, every counter reads 0, the run register reads 0, all status bits are 0, every irq line is low, and every match value reads 0xFFFFFFFF.
- R2: Bit c of the run register (word address 0) enables counter c. A stopped counter holds its value while the other counters keep counting.
- R3: In free-running mode (reload bit = 0), an enabled counter increases by 1 on every clock and wraps modulo 2^32.
- R4: In periodic mode (reload bit = 1), an enabled counter that holds the value of match 0 goes to 0 on the next clock. A match-0 value of N-1 therefore gives a period of N cycles, and periods of 16 cycles and more are supported.
- R5: A write that turns a counter's run bit from 0 to 1 restarts that counter from 0 if it is in periodic mode. In free-running mode the counter resumes from the value it held.
- R6: Status bit m of a counter is set on the clock edge at which the enabled counter's count equals match m. It then stays set until it is cleared.
- R7: Writing to the status offset clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. A match on the same edge as a clear leaves the bit set.
- R8: irq[c] is high exactly when some status bit m of counter c is set and interrupt-enable bit m of that counter is set.
- R9: Counter c has its registers at word base 8*(c+1). The offsets are 0..2 for match 0..2, 3 for the reload bit, 4 for the interrupt-enable bits, 5 for status and 6 for the count. The count is read-only, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | One interrupt line per counter |

## Verification
The hardest situation to reach is a status clear that lands on exactly the edge where the count meets its match value. This case decides whether the set or the clear wins. The bench tracks elapsed cycles from the enabling edge, waits for the periodic counter to reach the phase just before the match, and then issues the clear write so that it commits on the match edge. Random rounds on a third counter vary the period, the secondary match values, the interrupt enables and the wait time. Their status and irq results are compared against values computed from the elapsed cycle count.

// File: rtl/mct_pkg.sv
package mct_pkg;
   localparam int BLK_STRIDE  = 8;
   localparam int ADDR_RUN    = 0;
   localparam int OFS_PRELOAD = 3;
   localparam int OFS_IE      = 4;
   localparam int OFS_STAT    = 5;
   localparam int OFS_COUNT   = 6;
   localparam int MAX_MATCH   = 3;

   typedef enum logic {
      MODE_FREE     = 1'b0,
      MODE_PERIODIC = 1'b1
   } reload_mode_e;
endpackage

// File: rtl/mct_cmp.sv
module mct_cmp #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] match_val,
   input  logic             clr,
   output logic             hit
);
   // a match on the same edge as a clear wins
   always_ff @(posedge clk) begin
      if (!rst_n)                            hit <= 1'b0;
      else if (active && count == match_val) hit <= 1'b1;
      else if (clr)                          hit <= 1'b0;
   end
endmodule

// File: rtl/mct_channel.sv
module mct_channel
   import mct_pkg::*;
#(
   parameter int CNT_W     = 32,
   parameter int NUM_MATCH = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            run,
   input  logic                            restart,
   input  reload_mode_e                    mode,
   input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_val,
   input  logic [NUM_MATCH-1:0]            clr,
   input  logic [NUM_MATCH-1:0]            ie,
   output logic [CNT_W-1:0]                count,
   output logic [NUM_MATCH-1:0]            status,
   output logic                            irq
);
   logic wrap;

   assign wrap = (mode == MODE_PERIODIC) && (count == match_val[0]);

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (restart && mode == MODE_PERIODIC)
         count <= '0;
      else if (run)
         count <= wrap ? '0 : count + CNT_W'(1);
   end

   for (genvar m = 0; m < NUM_MATCH; m++) begin : g_cmp
      mct_cmp #(.CNT_W(CNT_W)) u_cmp (
         .clk       (clk),
         .rst_n     (rst_n),
         .active    (run),
         .count     (count),
         .match_val (match_val[m]),
         .clr       (clr[m]),
         .hit       (status[m])
      );
   end

   assign irq = |(status & ie);
endmodule

// File: rtl/mct_bank.sv
module mct_bank
   import mct_pkg::*;
#(
   parameter int NUM_CTR   = 3,
   parameter int NUM_MATCH = 3,
   parameter int CNT_W     = 32,
   localparam int ADDR_W   = $clog2(BLK_STRIDE * (NUM_CTR + 1))
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [CNT_W-1:0]   bus_wdata,
   output logic [CNT_W-1:0]   bus_rdata,
   output logic [NUM_CTR-1:0] irq
);
   if (NUM_MATCH < 1 || NUM_MATCH > MAX_MATCH) begin : g_bad_match
      $error("mct_bank: NUM_MATCH out of range");
   end
   if (NUM_CTR < 1 || NUM_CTR > CNT_W) begin : g_bad_ctr
      $error("mct_bank: NUM_CTR out of range");
   end
   if (CNT_W < 8) begin : g_bad_width
      $error("mct_bank: CNT_W too small");
   end

   logic [NUM_CTR-1:0]                            en_q;
   logic [NUM_CTR-1:0]                            preload_q;
   logic [NUM_CTR-1:0][NUM_MATCH-1:0]             ie_q;
   logic [NUM_CTR-1:0][NUM_MATCH-1:0][CNT_W-1:0]  match_q;
   logic [NUM_CTR-1:0][CNT_W-1:0]                 cnt_all;
   logic [NUM_CTR-1:0][NUM_MATCH-1:0]             stat_all;
   logic                                          run_wr;

   assign run_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_RUN));

   always_ff @(posedge clk) begin
      if (!rst_n)      en_q <= '0;
      else if (run_wr) en_q <= bus_wdata[NUM_CTR-1:0];
   end

   for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
      localparam int BASE = BLK_STRIDE * (c + 1);
      logic                 restart;
      logic [NUM_MATCH-1:0] clr;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            match_q[c]   <= '1;
            preload_q[c] <= 1'b0;
            ie_q[c]      <= '0;
         end else if (bus_wr) begin
            for (int m = 0; m < NUM_MATCH; m++)
               if (bus_addr == ADDR_W'(BASE + m)) match_q[c][m] <= bus_wdata;
            if (bus_addr == ADDR_W'(BASE + OFS_PRELOAD)) preload_q[c] <= bus_wdata[0];
            if (bus_addr == ADDR_W'(BASE + OFS_IE))      ie_q[c] <= bus_wdata[NUM_MATCH-1:0];
         end
      end

      assign clr     = (bus_wr && bus_addr == ADDR_W'(BASE + OFS_STAT))
                       ? bus_wdata[NUM_MATCH-1:0] : '0;
      assign restart = run_wr && bus_wdata[c] && !en_q[c];

      mct_channel #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .run       (en_q[c]),
         .restart   (restart),
         .mode      (reload_mode_e'(preload_q[c])),
         .match_val (match_q[c]),
         .clr       (clr),
         .ie        (ie_q[c]),
         .count     (cnt_all[c]),
         .status    (stat_all[c]),
         .irq       (irq[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADDR_RUN)) bus_rdata[NUM_CTR-1:0] = en_q;
      for (int c = 0; c < NUM_CTR; c++) begin
         for (int m = 0; m < NUM_MATCH; m++)
            if (bus_addr == ADDR_W'(BLK_STRIDE * (c + 1) + m)) bus_rdata = match_q[c][m];
         if (bus_addr == ADDR_W'(BLK_STRIDE * (c + 1) + OFS_PRELOAD))
            bus_rdata[0] = preload_q[c];
         if (bus_addr == ADDR_W'(BLK_STRIDE * (c + 1) + OFS_IE))
            bus_rdata[NUM_MATCH-1:0] = ie_q[c];
         if (bus_addr == ADDR_W'(BLK_STRIDE * (c + 1) + OFS_STAT))
            bus_rdata[NUM_MATCH-1:0] = stat_all[c];
         if (bus_addr == ADDR_W'(BLK_STRIDE * (c + 1) + OFS_COUNT))
            bus_rdata = cnt_all[c];
      end
   end
endmodule

// File: rtl/mct_bank_chk.sv
module mct_bank_chk
   import mct_pkg::*;
#(
   parameter int NUM_CTR   = 3,
   parameter int NUM_MATCH = 3,
   parameter int CNT_W     = 32,
   localparam int ADDR_W   = $clog2(BLK_STRIDE * (NUM_CTR + 1))
) (
   input logic                                    clk,
   input logic                                    rst_n,
   input logic                                    bus_wr,
   input logic [ADDR_W-1:0]                       bus_addr,
   input logic [CNT_W-1:0]                        bus_wdata,
   input logic [NUM_CTR-1:0]                      en_q,
   input logic [NUM_CTR-1:0]                      preload_q,
   input logic [NUM_CTR-1:0][NUM_MATCH-1:0][CNT_W-1:0] match_q,
   input logic [NUM_CTR-1:0][CNT_W-1:0]           cnt_all,
   input logic [NUM_CTR-1:0][NUM_MATCH-1:0]       stat_all,
   input logic [NUM_CTR-1:0]                      irq
);
   logic run_wr;
   assign run_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_RUN));

   for (genvar c = 0; c < NUM_CTR; c++) begin : g_c
      AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_q[c] && !run_wr) |=> $stable(cnt_all[c])); // R2
      AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[c] && !preload_q[c]) |=> cnt_all[c] == $past(cnt_all[c]) + CNT_W'(1)); // R3
      AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[c] && preload_q[c] && cnt_all[c] == match_q[c][0]) |=> cnt_all[c] == '0); // R4
      AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (run_wr && bus_wdata[c] && !en_q[c] && preload_q[c]) |=> cnt_all[c] == '0); // R5
      AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
         irq[c] |-> (stat_all[c] != '0)); // R8
      for (genvar m = 0; m < NUM_MATCH; m++) begin : g_m
         AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q[c] && cnt_all[c] == match_q[c][m]) |=> stat_all[c][m]); // R6
         AST_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_all[c][m]) |-> $past(bus_wr && bus_wdata[m] &&
               bus_addr == ADDR_W'(BLK_STRIDE * (c + 1) + OFS_STAT))); // R7
      end
   end
endmodule

bind mct_bank mct_bank_chk #(
   .NUM_CTR(NUM_CTR), .NUM_MATCH(NUM_MATCH), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .en_q(en_q), .preload_q(preload_q),
   .match_q(match_q), .cnt_all(cnt_all), .stat_all(stat_all), .irq(irq)
);

// File: tb/sim_mct_bank.sv
module sim_mct_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 1'b0;
   logic [2:0] en_sh = '0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   mct_bank u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [4:0] ra(input int c, input int ofs);
      return 5'(8 * (c + 1) + ofs);
   endfunction

   // expected status after 'el' edges of a periodic counter started at 0
   function automatic logic [2:0] exp_stat(input int n, input int m1, input int m2, input int el);
      int mv [3];
      logic [2:0] s;
      mv[0] = n - 1; mv[1] = m1; mv[2] = m2;
      s = '0;
      for (int m = 0; m < 3; m++) s[m] = (mv[m] <= n - 1) && (el >= mv[m] + 1);
      return s;
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, h0, h1, rv;
      int t0, t1, t, n, m1, m2, iev, w;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(5'd0, v); chk("R1 run reg", v, 32'h0);
      chk("R1 irq", {29'd0, irq}, 32'h0);
      for (int c = 0; c < 3; c++) begin
         rd(ra(c, 6), v); chk("R1 count", v, 32'h0);
         rd(ra(c, 5), v); chk("R1 status", v, 32'h0);
         rd(ra(c, 0), v); chk("R1 match", v, 32'hFFFF_FFFF);
      end

      // R9 register map readback, count read-only
      rv = $urandom;
      wr(ra(2, 1), rv); rd(ra(2, 1), v); chk("R9 match1 readback", v, rv);
      wr(ra(2, 3), 32'h1); rd(ra(2, 3), v); chk("R9 reload readback", v, 32'h1);
      wr(ra(2, 4), 32'h5); rd(ra(2, 4), v); chk("R9 ie readback", v, 32'h5);
      wr(ra(2, 6), 32'h1234); rd(ra(2, 6), v); chk("R9 count write ignored", v, 32'h0);
      wr(ra(2, 1), 32'hFFFF_FFFF); wr(ra(2, 4), 32'h0); wr(ra(2, 3), 32'h0);

      // R3 free-running counter 1
      en_sh = 3'b010; wr(5'd0, 32'(en_sh)); t1 = cyc;
      repeat (37) @(negedge clk);
      rd(ra(1, 6), v); chk("R3 free count", v, 32'(cyc - t1));

      // R4 R6 R8 periodic counter 0, match0 = 15
      wr(ra(0, 0), 32'd15); wr(ra(0, 3), 32'h1); wr(ra(0, 4), 32'h1);
      en_sh = 3'b011; wr(5'd0, 32'(en_sh)); t0 = cyc;
      rd(ra(0, 6), v); chk("R4 start at 0", v, 32'h0);
      repeat (15) @(negedge clk);
      rd(ra(0, 6), v); chk("R4 count before match", v, 32'd15);
      rd(ra(0, 5), v); chk("R6 status not yet set", v, 32'h0);
      chk("R8 irq low before match", {31'd0, irq[0]}, 32'h0);
      @(negedge clk);
      rd(ra(0, 5), v); chk("R6 status set on match", v, 32'h1);
      chk("R8 irq high", {31'd0, irq[0]}, 32'h1);
      rd(ra(0, 6), v); chk("R4 reload to 0", v, 32'h0);
      repeat (16) @(negedge clk);
      rd(ra(0, 6), v); chk("R4 second period", v, 32'h0);
      rd(ra(1, 6), v); chk("R2 neighbour running", v, 32'(cyc - t1));

      // R7 write-one-to-clear
      wr(ra(0, 5), 32'h6);
      rd(ra(0, 5), v); chk("R7 zero bits keep status", v, 32'h1);
      while (((cyc - t0) % 16) != 3) @(negedge clk);
      wr(ra(0, 5), 32'h1);
      rd(ra(0, 5), v); chk("R7 cleared", v, 32'h0);
      chk("R8 irq drops after clear", {31'd0, irq[0]}, 32'h0);
      while (((cyc - t0) % 16) != 14) @(negedge clk);
      wr(ra(0, 5), 32'h1);
      rd(ra(0, 6), v); chk("R7 clear landed on match edge", v, 32'h0);
      rd(ra(0, 5), v); chk("R7 set wins over clear", v, 32'h1);

      // R2 stop counter 0 only
      en_sh = 3'b010; wr(5'd0, 32'(en_sh));
      rd(ra(0, 6), h0);
      repeat (10) @(negedge clk);
      rd(ra(0, 6), v); chk("R2 stopped counter holds", v, h0);
      rd(ra(1, 6), v); chk("R2 other counter runs", v, 32'(cyc - t1));

      // R5 periodic restart and free-running resume
      en_sh = 3'b011; wr(5'd0, 32'(en_sh));
      rd(ra(0, 6), v); chk("R5 periodic restart at 0", v, 32'h0);
      repeat (5) @(negedge clk);
      rd(ra(0, 6), v); chk("R5 periodic counts after restart", v, 32'd5);
      en_sh = 3'b001; wr(5'd0, 32'(en_sh));
      rd(ra(1, 6), h1);
      repeat (7) @(negedge clk);
      en_sh = 3'b011; wr(5'd0, 32'(en_sh));
      repeat (4) @(negedge clk);
      rd(ra(1, 6), v); chk("R5 free resumes from held", v, h1 + 32'd4);

      // random rounds on counter 2 (R4 R6 R8)
      for (int it = 0; it < 20; it++) begin
         n = 16 + int'($urandom % 40);
         m1 = int'($urandom % 70);
         m2 = int'($urandom % 70);
         iev = int'($urandom % 8);
         w = 1 + int'($urandom % 100);
         en_sh[2] = 1'b0; wr(5'd0, 32'(en_sh));
         wr(ra(2, 0), 32'(n - 1)); wr(ra(2, 1), 32'(m1)); wr(ra(2, 2), 32'(m2));
         wr(ra(2, 3), 32'h1); wr(ra(2, 4), 32'(iev)); wr(ra(2, 5), 32'h7);
         en_sh[2] = 1'b1; wr(5'd0, 32'(en_sh)); t = cyc;
         repeat (w) @(negedge clk);
         rd(ra(2, 6), v); chk("R4 random period count", v, 32'((cyc - t) % n));
         rd(ra(2, 5), v);
         chk("R6 random status", v, {29'd0, exp_stat(n, m1, m2, cyc - t)});
         chk("R8 random irq", {31'd0, irq[2]},
             {31'd0, |(exp_stat(n, m1, m2, cyc - t) & 3'(iev))});
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule